// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Interrupts

This block controls up to 32 general-purpose pins that are split into two power-domain banks. Pins below a configurable boundary belong to the core bank. Pins at or above the boundary belong to the resume bank and are numbered from zero again inside that bank. Both banks have the same set of byte-addressed registers: pin enable, direction, level, rising-edge enable, falling-edge enable, event enable, a stored routing bit and trigger status. A host reaches these registers through a simple synchronous byte bus. Writes commit on the clock edge and reads return data combinationally in the same cycle.

Input pins pass through a two-flop synchronizer. Enabled pins then have their selected edges detected and latched into the trigger status register. The host acknowledges a latched edge by writing a 1 to its status bit. Every status bit that is unmasked by its event enable, in either bank, feeds a single level-sensitive event output. That output stays high until software clears every unmasked status bit or masks it.

Top module: `gpio_dual_bank`

## Requirements
- R1: Bus address bit 5 selects the bank (0 core, 1 resume). Bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event enable, 6 routing store, 7 trigger status. Bits 1:0 select the byte lane. A pin with bank-relative number n sits in lane n/8, bit n%8. The enable, edge-enable, event-enable and routing registers read back exactly what was written.
- R2: After reset every direction bit is 1 and every other register bit is 0. pin_oe and event_o are 0.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. pin_oe for a pin is 1 only when its enable bit is 1 and its direction bit is 0.
- R4: A write to the level register changes only the bits of output pins. Bits of input pins keep their stored value, and pin_out carries the stored level.
- R5: A level read returns the synchronized pin for inputs and the stored level for outputs. A pin change made between two clock edges is visible to a read after the second following edge and not after the first.
- R6: Rising and falling edge enables act independently, so a pin can trigger on rising edges, falling edges, or both. For a pin change made between two edges, the status bit reads 1 after the third following edge and 0 after the second.
- R7: A pin whose enable bit is 0 never sets its status bit.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clear, the bit stays set.
- R9: event_o is 1 exactly while some status bit in either bank has its event enable bit at 1.
- R10: Register bits beyond a bank's pin count, including whole lanes, read as 0 and ignore writes.
- R11: Global pin p maps to core bit p when p is below the boundary, and to resume bit p minus the boundary otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Bank, register and byte-lane select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access, 0 when idle |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_out | output | NUM_PINS | Stored output levels |
| pin_oe | output | NUM_PINS | Per-pin output drive enable |
| event_o | output | 1 | Combined level event from both banks |

## Verification
The bench builds the controller with 30 pins and the boundary at 21. With this configuration the core bank ends partway through its third lane and the resume bank holds a single bit in its second lane, so partially valid lanes, wholly empty lanes and the renumbering across the boundary are all exercised. Random register traffic over both banks is checked against a bench model with pins held static. Directed cases then cover the synchronizer latency, each edge-enable combination, acknowledging a bit while an edge lands in the same cycle, and the event output seen from each bank.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam logic [2:0] REG_EN   = 3'd0;
  localparam logic [2:0] REG_DIR  = 3'd1;
  localparam logic [2:0] REG_LVL  = 3'd2;
  localparam logic [2:0] REG_RISE = 3'd3;
  localparam logic [2:0] REG_FALL = 3'd4;
  localparam logic [2:0] REG_EVT  = 3'd5;
  localparam logic [2:0] REG_SMI  = 3'd6;
  localparam logic [2:0] REG_STS  = 3'd7;

  // replace one byte lane of a 32-bit register image
  function automatic logic [31:0] lane_merge(logic [31:0] old_v, logic [1:0] lane,
                                             logic [7:0] data);
    logic [31:0] r;
    r = old_v;
    r[int'(lane)*8 +: 8] = data;
    return r;
  endfunction

  function automatic logic [7:0] lane_pick(logic [31:0] v, logic [1:0] lane);
    return v[int'(lane)*8 +: 8];
  endfunction

  // ones in the low n bit positions
  function automatic logic [31:0] pin_mask(int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int BANK_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           reg_sel,
  input  logic [1:0]           lane,
  input  logic [7:0]           wdata,
  input  logic [BANK_PINS-1:0] pin_sync,
  output logic [7:0]           rdata,
  output logic [BANK_PINS-1:0] drv_val,
  output logic [BANK_PINS-1:0] drv_oe,
  output logic [BANK_PINS-1:0] edge_hit,
  output logic                 irq
);

  localparam logic [31:0] VALID = pin_mask(BANK_PINS);

  logic [31:0] en_q, dir_q, lvl_q, rise_q, fall_q, evt_q, smi_q, sts_q, prev_q;
  logic [31:0] pin32, raw_val, rd_val, wr_val, clr_mask;
  logic [31:0] rise_ev, fall_ev, hit32, oe32;

  always_comb begin
    pin32 = '0;
    pin32[BANK_PINS-1:0] = pin_sync;
  end

  // edge detection on the synchronized pin against its previous sample
  assign rise_ev = pin32 & ~prev_q & rise_q & en_q;
  assign fall_ev = ~pin32 & prev_q & fall_q & en_q;
  assign hit32   = (rise_ev | fall_ev) & VALID;

  always_comb begin
    case (reg_sel)
      REG_EN:   raw_val = en_q;
      REG_DIR:  raw_val = dir_q;
      REG_LVL:  raw_val = lvl_q;
      REG_RISE: raw_val = rise_q;
      REG_FALL: raw_val = fall_q;
      REG_EVT:  raw_val = evt_q;
      REG_SMI:  raw_val = smi_q;
      default:  raw_val = sts_q;
    endcase
    rd_val = (reg_sel == REG_LVL) ? ((lvl_q & ~dir_q) | (pin32 & dir_q)) : raw_val;
    rdata  = lane_pick(rd_val & VALID, lane);
  end

  assign wr_val   = lane_merge(raw_val, lane, wdata) & VALID;
  assign clr_mask = (wr_en && reg_sel == REG_STS) ? (lane_merge('0, lane, wdata) & VALID) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= VALID;
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      evt_q  <= '0;
      smi_q  <= '0;
      sts_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin32;
      sts_q  <= (sts_q & ~clr_mask) | hit32;
      if (wr_en) begin
        case (reg_sel)
          REG_EN:   en_q   <= wr_val;
          REG_DIR:  dir_q  <= wr_val;
          REG_LVL:  lvl_q  <= (wr_val & ~dir_q) | (lvl_q & dir_q);
          REG_RISE: rise_q <= wr_val;
          REG_FALL: fall_q <= wr_val;
          REG_EVT:  evt_q  <= wr_val;
          REG_SMI:  smi_q  <= wr_val;
          default:  ;
        endcase
      end
    end
  end

  assign oe32     = en_q & ~dir_q;
  assign drv_val  = lvl_q[BANK_PINS-1:0];
  assign drv_oe   = oe32[BANK_PINS-1:0];
  assign edge_hit = hit32[BANK_PINS-1:0];
  assign irq      = |(sts_q & evt_q);

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int RESUME_BASE = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [5:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                event_o
);

  localparam int CORE_PINS = RESUME_BASE;
  localparam int RES_PINS  = NUM_PINS - RESUME_BASE;

  logic [NUM_PINS-1:0]  pin_sync;
  logic [CORE_PINS-1:0] core_val, core_oe, core_hit;
  logic [RES_PINS-1:0]  res_val, res_oe, res_hit;
  logic [7:0]           core_rd, res_rd;
  logic                 core_irq, res_irq;
  logic                 core_wr, res_wr;
  logic [2:0]           reg_sel;
  logic [1:0]           lane;

  // named events for the checker
  logic bus_write, level_wr, evt_wr, oe_wr, any_edge;

  assign reg_sel   = bus_addr[4:2];
  assign lane      = bus_addr[1:0];
  assign bus_write = bus_en & bus_we;
  assign core_wr   = bus_write & ~bus_addr[5];
  assign res_wr    = bus_write &  bus_addr[5];
  assign level_wr  = bus_write & (reg_sel == REG_LVL);
  assign evt_wr    = bus_write & (reg_sel == REG_EVT);
  assign oe_wr     = bus_write & ((reg_sel == REG_EN) | (reg_sel == REG_DIR));

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_bank #(.BANK_PINS(CORE_PINS)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (core_wr),
    .reg_sel  (reg_sel),
    .lane     (lane),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync[CORE_PINS-1:0]),
    .rdata    (core_rd),
    .drv_val  (core_val),
    .drv_oe   (core_oe),
    .edge_hit (core_hit),
    .irq      (core_irq)
  );

  gpio_bank #(.BANK_PINS(RES_PINS)) u_resume (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (res_wr),
    .reg_sel  (reg_sel),
    .lane     (lane),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync[NUM_PINS-1:RESUME_BASE]),
    .rdata    (res_rd),
    .drv_val  (res_val),
    .drv_oe   (res_oe),
    .edge_hit (res_hit),
    .irq      (res_irq)
  );

  assign any_edge  = (|core_hit) | (|res_hit);
  assign bus_rdata = !bus_en ? 8'h00 : (bus_addr[5] ? res_rd : core_rd);
  assign pin_out   = {res_val, core_val};
  assign pin_oe    = {res_oe, core_oe};
  assign event_o   = core_irq | res_irq;

endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_write,
  input logic                level_wr,
  input logic                evt_wr,
  input logic                oe_wr,
  input logic                any_edge,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                event_o
);

  // R4: stored output levels move only on a level-register write
  assert_level_only_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !level_wr |=> $stable(pin_out));

  // R3: drive enables move only on an enable or direction write
  assert_oe_only_by_config_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(oe_wr));

  // R9: the event rises only after a detected edge or an event-enable write
  assert_event_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(event_o) |-> ($past(any_edge) || $past(evt_wr)));

  // R8: the event falls only after a bus write (acknowledge or mask)
  assert_event_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(event_o) |-> $past(bus_write));

  // R2: outputs are quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R2: assert (pin_oe == '0 && event_o == 1'b0);
    end
  end

endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_write (bus_write),
  .level_wr  (level_wr),
  .evt_wr    (evt_wr),
  .oe_wr     (oe_wr),
  .any_edge  (any_edge),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .event_o   (event_o)
);

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 30;
  localparam int RB = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          event_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m [2][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dual_bank #(.NUM_PINS(NP), .RESUME_BASE(RB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .event_o(event_o)
  );

  function automatic logic [31:0] vmask(int b);
    return b != 0 ? 32'h0000_01FF : 32'h001F_FFFF;
  endfunction

  function automatic logic [5:0] addr_of(int b, int r, int ln);
    return 6'(b * 32 + r * 4 + ln);
  endfunction

  function automatic logic [31:0] bank_pins(int b);
    return b != 0 ? 32'(pin_in[NP-1:RB]) : 32'(pin_in[RB-1:0]);
  endfunction

  function automatic logic [7:0] exp_read(int b, int r, int ln);
    logic [31:0] v;
    if (r == 2) v = ((m[b][2] & ~m[b][1]) | (bank_pins(b) & m[b][1])) & vmask(b);
    else        v = m[b][r];
    return v[ln*8 +: 8];
  endfunction

  function automatic void mdl_write(int b, int r, int ln, logic [7:0] d);
    logic [31:0] nv;
    nv = m[b][r];
    nv[ln*8 +: 8] = d;
    nv = nv & vmask(b);
    if (r == 2) m[b][r] = (nv & ~m[b][1]) | (m[b][r] & m[b][1]);
    else if (r != 7) m[b][r] = nv;
  endfunction

  function automatic void mdl_reset();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++)
        m[b][r] = (r == 1) ? vmask(b) : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    mdl_reset();
    // reset state, outputs sampled while reset is held (R2)
    idle(2);
    check("R2 oe in reset", 32'(pin_oe), 32'h0);
    check("R2 event in reset", 32'(event_o), 32'h0);
    rst_n = 1'b1;

    // ---------------- random register traffic, static pins ----------------
    pin_in = NP'($urandom);
    idle(3);
    for (int i = 0; i < 300; i++) begin
      int b, r, ln, b2, r2, ln2;
      logic [7:0] d;
      b  = int'($urandom % 2);
      r  = int'($urandom % 7);
      ln = int'($urandom % 4);
      d  = 8'($urandom);
      bus_write(addr_of(b, r, ln), d);
      mdl_write(b, r, ln, d);
      b2  = int'($urandom % 2);
      r2  = int'($urandom % 8);
      ln2 = int'($urandom % 4);
      bus_read(addr_of(b2, r2, ln2), rd);
      check("R1 R10 random readback", 32'(rd), 32'(exp_read(b2, r2, ln2)));
      check("R4 pin_out model", 32'(pin_out), 32'({m[1][2][8:0], m[0][2][20:0]}));
      check("R3 pin_oe model", 32'(pin_oe),
            32'({m[1][0][8:0] & ~m[1][1][8:0], m[0][0][20:0] & ~m[0][1][20:0]}));
      check("R9 no edges no event", 32'(event_o), 32'h0);
    end

    // ---------------- directed cases ----------------
    do_reset();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++)
        for (int ln = 0; ln < 4; ln++) begin
          bus_read(addr_of(b, r, ln), rd);
          check("R2 reset register value", 32'(rd), 32'(exp_read(b, r, ln)));
        end

    // R10: lanes and bits past the pin count
    bus_write(addr_of(0, 0, 3), 8'hFF);
    bus_read(addr_of(0, 0, 3), rd);
    check("R10 core empty lane", 32'(rd), 32'h00);
    bus_write(addr_of(0, 0, 2), 8'hFF);
    bus_read(addr_of(0, 0, 2), rd);
    check("R10 core partial lane", 32'(rd), 32'h1F);
    bus_write(addr_of(1, 6, 1), 8'hFF);
    bus_read(addr_of(1, 6, 1), rd);
    check("R10 resume partial lane", 32'(rd), 32'h01);
    bus_write(addr_of(1, 6, 2), 8'hFF);
    bus_read(addr_of(1, 6, 2), rd);
    check("R10 resume empty lane", 32'(rd), 32'h00);

    // R3/R4: pin 3 as output, level write to input bits ignored
    bus_write(addr_of(0, 0, 0), 8'h08);
    bus_write(addr_of(0, 1, 0), 8'hF7);
    bus_write(addr_of(0, 2, 0), 8'hFF);
    check("R3 oe pin3 only", 32'(pin_oe[7:0]), 32'h08);
    check("R4 input bits ignore level write", 32'(pin_out[7:0]), 32'h08);
    bus_write(addr_of(0, 2, 0), 8'h00);
    check("R4 output drops to 0", 32'(pin_out[7:0]), 32'h00);
    bus_write(addr_of(0, 2, 0), 8'h08);

    // R5: readback mixes inputs and stored outputs; two-edge latency
    @(negedge clk);
    pin_in[0] = 1'b1;
    pin_in[3] = 1'b0;
    idle(3);
    bus_read(addr_of(0, 2, 0), rd);
    check("R5 level readback", 32'(rd), 32'h09);
    @(negedge clk);
    pin_in[1] = 1'b1;
    bus_read(addr_of(0, 2, 0), rd);
    check("R5 not after one edge", 32'(rd), 32'h09);
    bus_read(addr_of(0, 2, 0), rd);
    check("R5 after two edges", 32'(rd), 32'h0B);

    // R6: rising edge on pin 22 = resume bit 1
    bus_write(addr_of(1, 0, 0), 8'h02);
    bus_write(addr_of(1, 3, 0), 8'h02);
    @(negedge clk);
    pin_in[22] = 1'b1;
    @(negedge clk);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 status not after two edges", 32'(rd), 32'h00);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 rising status after three edges", 32'(rd), 32'h02);

    // R8: write 0 keeps, write 1 clears
    bus_write(addr_of(1, 7, 0), 8'h00);
    bus_read(addr_of(1, 7, 0), rd);
    check("R8 zero write keeps", 32'(rd), 32'h02);
    bus_write(addr_of(1, 7, 0), 8'h02);
    bus_read(addr_of(1, 7, 0), rd);
    check("R8 one write clears", 32'(rd), 32'h00);

    // R6: falling edge not enabled
    @(negedge clk);
    pin_in[22] = 1'b0;
    idle(4);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 falling ignored when rise only", 32'(rd), 32'h00);
    // falling only
    bus_write(addr_of(1, 3, 0), 8'h00);
    bus_write(addr_of(1, 4, 0), 8'h02);
    @(negedge clk);
    pin_in[22] = 1'b1;
    idle(4);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 rising ignored when fall only", 32'(rd), 32'h00);
    @(negedge clk);
    pin_in[22] = 1'b0;
    idle(4);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 falling captured", 32'(rd), 32'h02);

    // R9: masked status, then unmask, then acknowledge
    check("R9 masked status no event", 32'(event_o), 32'h0);
    bus_write(addr_of(1, 5, 0), 8'h02);
    check("R9 unmasked status raises event", 32'(event_o), 32'h1);
    bus_write(addr_of(1, 7, 0), 8'h02);
    check("R9 ack drops event", 32'(event_o), 32'h0);

    // R6: both edges enabled
    bus_write(addr_of(1, 3, 0), 8'h02);
    @(negedge clk);
    pin_in[22] = 1'b1;
    idle(4);
    bus_read(addr_of(1, 7, 0), rd);
    check("R6 both: rising", 32'(rd), 32'h02);
    bus_write(addr_of(1, 7, 0), 8'h02);
    // R8: falling edge lands in the cycle of the clear
    @(negedge clk);
    pin_in[22] = 1'b0;
    @(negedge clk);
    bus_write(addr_of(1, 7, 0), 8'h02);
    bus_read(addr_of(1, 7, 0), rd);
    check("R8 edge wins over clear", 32'(rd), 32'h02);
    check("R9 event follows resume status", 32'(event_o), 32'h1);
    bus_write(addr_of(1, 7, 0), 8'h02);
    check("R9 event low after ack", 32'(event_o), 32'h0);

    // R9/R11: core pin 5 raises the event
    bus_write(addr_of(0, 0, 0), 8'h28);
    bus_write(addr_of(0, 3, 0), 8'h20);
    bus_write(addr_of(0, 5, 0), 8'h20);
    @(negedge clk);
    pin_in[5] = 1'b1;
    idle(4);
    check("R9 core event", 32'(event_o), 32'h1);
    bus_read(addr_of(0, 7, 0), rd);
    check("R11 core pin5 status bit", 32'(rd), 32'h20);
    bus_write(addr_of(0, 7, 0), 8'h20);
    check("R9 core ack", 32'(event_o), 32'h0);

    // R7: pin 12 (core lane1 bit4) edge enabled but pin disabled
    bus_write(addr_of(0, 3, 1), 8'h10);
    @(negedge clk);
    pin_in[12] = 1'b1;
    idle(4);
    bus_read(addr_of(0, 7, 1), rd);
    check("R7 disabled pin no status", 32'(rd), 32'h00);

    // R11: pin 29 is resume bit 8 (lane1 bit0); pin 20 is core lane2 bit4
    bus_write(addr_of(1, 0, 1), 8'h01);
    bus_write(addr_of(1, 3, 1), 8'h01);
    bus_write(addr_of(0, 3, 2), 8'h10);
    @(negedge clk);
    pin_in[29] = 1'b1;
    idle(4);
    bus_read(addr_of(1, 7, 1), rd);
    check("R11 resume renumbered bit", 32'(rd), 32'h01);
    bus_read(addr_of(0, 7, 2), rd);
    check("R11 core bank untouched", 32'(rd), 32'h00);
    @(negedge clk);
    pin_in[20] = 1'b1;
    idle(4);
    bus_read(addr_of(0, 7, 2), rd);
    check("R11 core top pin", 32'(rd), 32'h10);

    finish_run();
  end

endmodule